// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a PLL through a safe change of its divider settings. A caller presents new main, pre, post and fractional divider values with a one-cycle request strobe. When the main and pre values equal those already applied, the block takes a fast path: it rewrites only the post divider, plus the fractional word in fractional mode, and leaves the PLL running. Otherwise it runs a full sequence. In integer mode it first sets lock-select. It then pulls the active-low reset low, sets bypass and loads all dividers. It holds reset for a timed interval, releases reset and waits for lock. Once lock is seen it leaves bypass. If lock does not arrive within the timeout window, the block reports an error and keeps bypass set.

Separate power-up and power-down requests are also handled. Power-up is skipped when reset is already released. Otherwise it bypasses the PLL, releases reset, waits for lock and un-bypasses. Power-down only asserts reset. All timing comes from a cycles-per-microsecond parameter, the hold length in microseconds and the lock timeout in microseconds.

States: IDLE (accepts requests), FAST (post/fractional rewrite), LSEL (set lock-select), RSTON (assert reset), BYPON (set bypass), LOAD (write all dividers), HOLD (timed reset hold), UPBYP and UPREL (power-up bypass and release), LOCKW (lock wait with timeout). The transitions are:
- IDLE→FAST when the main and pre values match.
- IDLE→LSEL or IDLE→RSTON for a full sequence.
- IDLE→UPBYP for power-up.
- LSEL→RSTON→BYPON→LOAD→HOLD.
- HOLD→LOCKW when the hold expires.
- UPBYP→UPREL→LOCKW.
- LOCKW→IDLE on lock or on timeout.
- FAST→IDLE.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset: reset-bar low, bypass low, lock-select low, busy, done and timeout error low, dividers at their parameter reset values.
- R2: A configuration request whose main and pre values equal the current ones updates only the post divider (and the fractional word when FRAC_MODE=1) one cycle after acceptance, with done high in that same cycle; reset-bar and bypass are unchanged.
- R3: Otherwise, counted in clock edges after the accepting edge: reset-bar falls at edge 1, bypass rises at edge 2 and all dividers load at edge 3 (each one edge later in integer mode).
- R4: Lock-select is set at the first edge of a full sequence only when FRAC_MODE=0; with FRAC_MODE=1 it stays low.
- R5: Reset-bar rises exactly HOLD_US*CYC_PER_US edges after the dividers load.
- R6: In the lock wait, the edge that samples lock high clears bypass, pulses done for one cycle and drops busy.
- R7: If lock is not seen within LOCK_TIMEOUT_US*CYC_PER_US cycles of the wait, timeout error goes high and stays high until the next accepted request, bypass stays high, busy drops and no done is given.
- R8: A power-up request while reset-bar is high changes nothing.
- R9: A power-up request while reset-bar is low sets bypass, releases reset-bar on the next edge, then enters the lock wait.
- R10: A power-down request clears reset-bar, leaves bypass and dividers untouched, and pulses done on the same edge.
- R11: Any request arriving while busy is ignored.
- R12: Requests in the same cycle are served with configuration above power-up above power-down; an ignored power-up still blocks power-down.
- R13: Busy is high from the accepting edge until the completing edge, and done is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Divider change request strobe |
| cfg_mdiv | input | MDIV_W | Requested main divider |
| cfg_pdiv | input | PDIV_W | Requested pre divider |
| cfg_sdiv | input | SDIV_W | Requested post divider |
| cfg_kdiv | input | KDIV_W | Requested fractional word |
| pwr_up_req | input | 1 | Power-up request strobe |
| pwr_down_req | input | 1 | Power-down request strobe |
| pll_lock | input | 1 | Lock status from the PLL |
| pll_lock_sel | output | 1 | Lock-select control bit |
| pll_rst_b | output | 1 | Active-low PLL reset |
| pll_bypass | output | 1 | Bypass control bit |
| pll_mdiv | output | MDIV_W | Applied main divider |
| pll_pdiv | output | PDIV_W | Applied pre divider |
| pll_sdiv | output | SDIV_W | Applied post divider |
| pll_kdiv | output | KDIV_W | Applied fractional word |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle success pulse |
| seq_timeout | output | 1 | Lock wait timed out |

## Verification
Configuration requests are tried in several forms:
- one matching the current main and pre values, which separates the fast path from the full sequence;
- changed main values with lock arriving a few cycles after release, which exposes the edge order and the exact hold length;
- one with lock held off, which separates a lock-driven completion from a timeout.

Power-up is issued both with reset released and with reset held, and a second request is sent mid-sequence, so an ignored request shows as unchanged outputs. Simultaneous requests are issued to expose the priority order.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FAST,
        ST_LSEL,
        ST_RSTON,
        ST_BYPON,
        ST_LOAD,
        ST_HOLD,
        ST_UPBYP,
        ST_UPREL,
        ST_LOCKW
    } seq_state_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pll_div_regs.sv
module pll_div_regs #(
    parameter int MW      = 10,
    parameter int PW      = 6,
    parameter int SW      = 3,
    parameter int KW      = 16,
    parameter bit FRAC    = 1'b1,
    parameter int RST_M   = 200,
    parameter int RST_P   = 3,
    parameter int RST_S   = 0,
    parameter int RST_K   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_all,
    input  logic          load_post,
    input  logic [MW-1:0] in_m,
    input  logic [PW-1:0] in_p,
    input  logic [SW-1:0] in_s,
    input  logic [KW-1:0] in_k,
    input  logic [MW-1:0] cmp_m,
    input  logic [PW-1:0] cmp_p,
    output logic [MW-1:0] m,
    output logic [PW-1:0] p,
    output logic [SW-1:0] s,
    output logic [KW-1:0] k,
    output logic          mp_same
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m <= MW'(RST_M);
            p <= PW'(RST_P);
            s <= SW'(RST_S);
        end else begin
            if (load_all) begin
                m <= in_m;
                p <= in_p;
            end
            if (load_all || load_post) begin
                s <= in_s;
            end
        end
    end

    generate
        if (FRAC) begin : g_frac
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    k <= KW'(RST_K);
                end else if (load_all || load_post) begin
                    k <= in_k;
                end
            end
        end else begin : g_int
            assign k = KW'(RST_K);
        end
    endgenerate

    assign mp_same = (cmp_m == m) && (cmp_p == p);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter int MDIV_W          = 10,
    parameter int PDIV_W          = 6,
    parameter int SDIV_W          = 3,
    parameter int KDIV_W          = 16,
    parameter bit FRAC_MODE       = 1'b1,
    parameter int CYC_PER_US      = 100,
    parameter int HOLD_US         = 3,
    parameter int LOCK_TIMEOUT_US = 10000,
    parameter int RST_MDIV        = 200,
    parameter int RST_PDIV        = 3,
    parameter int RST_SDIV        = 0,
    parameter int RST_KDIV        = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic [MDIV_W-1:0] cfg_mdiv,
    input  logic [PDIV_W-1:0] cfg_pdiv,
    input  logic [SDIV_W-1:0] cfg_sdiv,
    input  logic [KDIV_W-1:0] cfg_kdiv,
    input  logic              pwr_up_req,
    input  logic              pwr_down_req,
    input  logic              pll_lock,
    output logic              pll_lock_sel,
    output logic              pll_rst_b,
    output logic              pll_bypass,
    output logic [MDIV_W-1:0] pll_mdiv,
    output logic [PDIV_W-1:0] pll_pdiv,
    output logic [SDIV_W-1:0] pll_sdiv,
    output logic [KDIV_W-1:0] pll_kdiv,
    output logic              seq_busy,
    output logic              seq_done,
    output logic              seq_timeout
);

    localparam int HOLD_CYC = HOLD_US * CYC_PER_US;
    localparam int LOCK_CYC = LOCK_TIMEOUT_US * CYC_PER_US;
    localparam int MAX_CYC  = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
    localparam int TMR_W    = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] HOLD_LD = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] LOCK_LD = TMR_W'(LOCK_CYC - 1);

    seq_state_e state, nxt;

    logic [MDIV_W-1:0] stg_m;
    logic [PDIV_W-1:0] stg_p;
    logic [SDIV_W-1:0] stg_s;
    logic [KDIV_W-1:0] stg_k;

    logic mp_same, tmr_zero, tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic acc_cfg, acc_up, acc_down;

    // Request acceptance with fixed priority: configuration, power-up, power-down
    assign acc_cfg  = (state == ST_IDLE) && cfg_req;
    assign acc_up   = (state == ST_IDLE) && !cfg_req && pwr_up_req && !pll_rst_b;
    assign acc_down = (state == ST_IDLE) && !cfg_req && !pwr_up_req && pwr_down_req;

    assign tmr_load = (state == ST_LOAD) || (state == ST_UPREL) ||
                      ((state == ST_HOLD) && tmr_zero);
    assign tmr_val  = (state == ST_LOAD) ? HOLD_LD : LOCK_LD;

    pll_seq_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    pll_div_regs #(
        .MW(MDIV_W), .PW(PDIV_W), .SW(SDIV_W), .KW(KDIV_W), .FRAC(FRAC_MODE),
        .RST_M(RST_MDIV), .RST_P(RST_PDIV), .RST_S(RST_SDIV), .RST_K(RST_KDIV)
    ) u_divs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_all  (state == ST_LOAD),
        .load_post (state == ST_FAST),
        .in_m      (stg_m),
        .in_p      (stg_p),
        .in_s      (stg_s),
        .in_k      (stg_k),
        .cmp_m     (cfg_mdiv),
        .cmp_p     (cfg_pdiv),
        .m         (pll_mdiv),
        .p         (pll_pdiv),
        .s         (pll_sdiv),
        .k         (pll_kdiv),
        .mp_same   (mp_same)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_cfg) begin
                    if (mp_same)        nxt = ST_FAST;
                    else if (FRAC_MODE) nxt = ST_RSTON;
                    else                nxt = ST_LSEL;
                end else if (acc_up) begin
                    nxt = ST_UPBYP;
                end
            end
            ST_FAST:  nxt = ST_IDLE;
            ST_LSEL:  nxt = ST_RSTON;
            ST_RSTON: nxt = ST_BYPON;
            ST_BYPON: nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_HOLD;
            ST_HOLD:  nxt = tmr_zero ? ST_LOCKW : ST_HOLD;
            ST_UPBYP: nxt = ST_UPREL;
            ST_UPREL: nxt = ST_LOCKW;
            ST_LOCKW: nxt = (pll_lock || tmr_zero) ? ST_IDLE : ST_LOCKW;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Registered outputs and request staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_lock_sel <= 1'b0;
            pll_rst_b    <= 1'b0;
            pll_bypass   <= 1'b0;
            seq_busy     <= 1'b0;
            seq_done     <= 1'b0;
            seq_timeout  <= 1'b0;
            stg_m        <= '0;
            stg_p        <= '0;
            stg_s        <= '0;
            stg_k        <= '0;
        end else begin
            seq_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (acc_cfg) begin
                        seq_busy    <= 1'b1;
                        seq_timeout <= 1'b0;
                        stg_m       <= cfg_mdiv;
                        stg_p       <= cfg_pdiv;
                        stg_s       <= cfg_sdiv;
                        stg_k       <= cfg_kdiv;
                    end else if (acc_up) begin
                        seq_busy    <= 1'b1;
                        seq_timeout <= 1'b0;
                    end else if (acc_down) begin
                        pll_rst_b   <= 1'b0;
                        seq_done    <= 1'b1;
                        seq_timeout <= 1'b0;
                    end
                end
                ST_FAST: begin
                    seq_done <= 1'b1;
                    seq_busy <= 1'b0;
                end
                ST_LSEL:  pll_lock_sel <= 1'b1;
                ST_RSTON: pll_rst_b    <= 1'b0;
                ST_BYPON: pll_bypass   <= 1'b1;
                ST_LOAD:  ;
                ST_HOLD:  if (tmr_zero) pll_rst_b <= 1'b1;
                ST_UPBYP: pll_bypass   <= 1'b1;
                ST_UPREL: pll_rst_b    <= 1'b1;
                ST_LOCKW: begin
                    if (pll_lock) begin
                        pll_bypass <= 1'b0;
                        seq_done   <= 1'b1;
                        seq_busy   <= 1'b0;
                    end else if (tmr_zero) begin
                        seq_timeout <= 1'b1;
                        seq_busy    <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int MDIV_W    = 10,
    parameter bit FRAC_MODE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_lock,
    input logic              pll_lock_sel,
    input logic              pll_rst_b,
    input logic              pll_bypass,
    input logic [MDIV_W-1:0] pll_mdiv,
    input logic              seq_busy,
    input logic              seq_done,
    input logic              seq_timeout
);

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !seq_busy);                                          // R13

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);                                          // R6

    AST_RELEASE_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rst_b) |-> pll_bypass);                                 // R3

    AST_DIV_LOAD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_mdiv) |-> !pll_rst_b);                               // R3

    AST_TIMEOUT_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_timeout) |-> (pll_bypass && !seq_busy));                // R7

    AST_UNBYPASS_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_bypass) |-> $past(pll_lock));                           // R6

    generate
        if (FRAC_MODE) begin : g_frac_chk
            AST_NO_LSEL_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
                !pll_lock_sel);                                           // R4
        end
    endgenerate

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .MDIV_W    (MDIV_W),
    .FRAC_MODE (FRAC_MODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_lock     (pll_lock),
    .pll_lock_sel (pll_lock_sel),
    .pll_rst_b    (pll_rst_b),
    .pll_bypass   (pll_bypass),
    .pll_mdiv     (pll_mdiv),
    .seq_busy     (seq_busy),
    .seq_done     (seq_done),
    .seq_timeout  (seq_timeout)
);

// File: tb/test_pll_reprog_seq.sv
`timescale 1ns/1ps
module test_pll_reprog_seq;

    localparam int CPU      = 2;
    localparam int HOLD_CYC = 3 * CPU;
    localparam int LOCK_CYC = 10000 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_req = 1'b0, pwr_up_req = 1'b0, pwr_down_req = 1'b0;
    logic [9:0]  cfg_mdiv = '0;
    logic [5:0]  cfg_pdiv = '0;
    logic [2:0]  cfg_sdiv = '0;
    logic [15:0] cfg_kdiv = '0;
    logic pll_lock;
    logic pll_lock_sel, pll_rst_b, pll_bypass, seq_busy, seq_done, seq_timeout;
    logic [9:0]  pll_mdiv;
    logic [5:0]  pll_pdiv;
    logic [2:0]  pll_sdiv;
    logic [15:0] pll_kdiv;

    int checks = 0, failures = 0;
    bit fin = 1'b0;
    string cur_tag = "R1";
    bit lock_en = 1'b1;
    int lock_cnt = 0;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(.CYC_PER_US(CPU)) i_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_mdiv(cfg_mdiv),
        .cfg_pdiv(cfg_pdiv), .cfg_sdiv(cfg_sdiv), .cfg_kdiv(cfg_kdiv),
        .pwr_up_req(pwr_up_req), .pwr_down_req(pwr_down_req), .pll_lock(pll_lock),
        .pll_lock_sel(pll_lock_sel), .pll_rst_b(pll_rst_b), .pll_bypass(pll_bypass),
        .pll_mdiv(pll_mdiv), .pll_pdiv(pll_pdiv), .pll_sdiv(pll_sdiv), .pll_kdiv(pll_kdiv),
        .seq_busy(seq_busy), .seq_done(seq_done), .seq_timeout(seq_timeout)
    );

    // PLL stand-in: lock rises four cycles after reset release
    always @(negedge clk) begin
        if (!pll_rst_b) lock_cnt <= 0;
        else if (lock_cnt < 100) lock_cnt <= lock_cnt + 1;
    end
    assign pll_lock = lock_en && (lock_cnt >= 4);

    // Behavioural reference model: op 0 idle, 1 fast, 2 full, 3 power-up, 4 lock wait
    int op, step, wcnt;
    logic [9:0] e_m, s_m;
    logic [5:0] e_p, s_p;
    logic [2:0] e_s, s_s;
    logic [15:0] e_k, s_k;
    logic e_lsel, e_rstb, e_byp, e_busy, e_done, e_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op = 0; step = 0; wcnt = 0;
            e_m = 10'd200; e_p = 6'd3; e_s = 3'd0; e_k = 16'd0;
            s_m = '0; s_p = '0; s_s = '0; s_k = '0;
            e_lsel = 0; e_rstb = 0; e_byp = 0; e_busy = 0; e_done = 0; e_err = 0;
        end else begin
            e_done = 0;
            if (op == 0) begin
                if (cfg_req) begin
                    e_err = 0; e_busy = 1;
                    s_m = cfg_mdiv; s_p = cfg_pdiv; s_s = cfg_sdiv; s_k = cfg_kdiv;
                    if (cfg_mdiv == e_m && cfg_pdiv == e_p) op = 1;
                    else begin op = 2; step = 1; end
                end else if (pwr_up_req) begin
                    if (!e_rstb) begin e_err = 0; e_busy = 1; op = 3; step = 0; end
                end else if (pwr_down_req) begin
                    e_err = 0; e_rstb = 0; e_done = 1;
                end
            end else if (op == 1) begin
                e_s = s_s; e_k = s_k; e_done = 1; e_busy = 0; op = 0;
            end else if (op == 2) begin
                if (step == 1) begin e_rstb = 0; step = 2; end
                else if (step == 2) begin e_byp = 1; step = 3; end
                else if (step == 3) begin
                    e_m = s_m; e_p = s_p; e_s = s_s; e_k = s_k; step = 4; wcnt = 0;
                end else begin
                    wcnt++;
                    if (wcnt == HOLD_CYC) begin e_rstb = 1; op = 4; wcnt = 0; end
                end
            end else if (op == 3) begin
                if (step == 0) begin e_byp = 1; step = 1; end
                else begin e_rstb = 1; op = 4; wcnt = 0; end
            end else begin
                wcnt++;
                if (pll_lock) begin e_byp = 0; e_done = 1; e_busy = 0; op = 0; end
                else if (wcnt == LOCK_CYC) begin e_err = 1; e_busy = 0; op = 0; end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            checks++;
            if ({pll_lock_sel, pll_rst_b, pll_bypass, seq_busy, seq_done, seq_timeout,
                 pll_mdiv, pll_pdiv, pll_sdiv, pll_kdiv} !==
                {e_lsel, e_rstb, e_byp, e_busy, e_done, e_err, e_m, e_p, e_s, e_k}) begin
                failures++;
                $display("FAIL %s cycle compare actual=%h expected=%h", cur_tag,
                    {pll_lock_sel, pll_rst_b, pll_bypass, seq_busy, seq_done, seq_timeout,
                     pll_mdiv, pll_pdiv, pll_sdiv, pll_kdiv},
                    {e_lsel, e_rstb, e_byp, e_busy, e_done, e_err, e_m, e_p, e_s, e_k});
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_cfg(input logic [9:0] m, input logic [5:0] p,
                            input logic [2:0] s, input logic [15:0] k,
                            input logic up, input logic dn);
        @(negedge clk);
        cfg_req = 1'b1; pwr_up_req = up; pwr_down_req = dn;
        cfg_mdiv = m; cfg_pdiv = p; cfg_sdiv = s; cfg_kdiv = k;
        @(negedge clk);
        cfg_req = 1'b0; pwr_up_req = 1'b0; pwr_down_req = 1'b0;
    endtask

    task automatic send_pwr(input logic up, input logic dn);
        @(negedge clk);
        pwr_up_req = up; pwr_down_req = dn;
        @(negedge clk);
        pwr_up_req = 1'b0; pwr_down_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 30000 && seq_busy; n++) @(negedge clk);
    endtask

    int i_fall, i_byp, i_load, i_rise;
    logic pr_rstb, pr_byp;
    logic [9:0] pr_m;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rst_b", pll_rst_b, 0);
        chk("R1 bypass", pll_bypass, 0);
        chk("R1 busy", seq_busy, 0);
        chk("R1 mdiv", pll_mdiv, 200);

        // R2 fast path
        cur_tag = "R2";
        send_cfg(10'd200, 6'd3, 3'd2, 16'd1234, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 sdiv", pll_sdiv, 2);
        chk("R2 kdiv", pll_kdiv, 1234);
        chk("R2 rst_b untouched", pll_rst_b, 0);
        chk("R2 done", seq_done, 1);

        // R9 power-up from reset
        cur_tag = "R9";
        send_pwr(1'b1, 1'b0);
        chk("R9 busy", seq_busy, 1);
        wait_idle();
        chk("R9 rst_b", pll_rst_b, 1);
        chk("R9 bypass cleared", pll_bypass, 0);

        // R8 power-up while running
        cur_tag = "R8";
        send_pwr(1'b1, 1'b0);
        chk("R8 busy", seq_busy, 0);
        @(negedge clk);
        chk("R8 done", seq_done, 0);
        chk("R8 rst_b", pll_rst_b, 1);

        // R3 / R4 / R5 / R6 full sequence
        cur_tag = "R3";
        send_cfg(10'd250, 6'd3, 3'd1, 16'd77, 1'b0, 1'b0);
        chk("R13 busy", seq_busy, 1);
        i_fall = -1; i_byp = -1; i_load = -1; i_rise = -1;
        pr_rstb = pll_rst_b; pr_byp = pll_bypass; pr_m = pll_mdiv;
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            if (pr_rstb && !pll_rst_b && i_fall < 0) i_fall = i;
            if (!pr_byp && pll_bypass && i_byp < 0) i_byp = i;
            if (pll_mdiv != pr_m && i_load < 0) i_load = i;
            if (!pr_rstb && pll_rst_b && i_rise < 0) i_rise = i;
            pr_rstb = pll_rst_b; pr_byp = pll_bypass; pr_m = pll_mdiv;
        end
        chk("R3 reset edge", i_fall, 1);
        chk("R3 bypass edge", i_byp, 2);
        chk("R3 load edge", i_load, 3);
        chk("R5 hold length", i_rise - i_load, HOLD_CYC);
        chk("R4 lock_sel low", pll_lock_sel, 0);
        cur_tag = "R6";
        wait_idle();
        chk("R6 bypass cleared", pll_bypass, 0);
        chk("R6 mdiv", pll_mdiv, 250);

        // R11 request while busy
        cur_tag = "R11";
        send_cfg(10'd300, 6'd3, 3'd1, 16'd5, 1'b0, 1'b0);
        @(negedge clk);
        send_cfg(10'd350, 6'd3, 3'd2, 16'd9, 1'b0, 1'b0);
        wait_idle();
        chk("R11 mdiv", pll_mdiv, 300);
        chk("R11 sdiv", pll_sdiv, 1);

        // R7 lock timeout
        cur_tag = "R7";
        lock_en = 1'b0;
        send_cfg(10'd325, 6'd3, 3'd2, 16'd0, 1'b0, 1'b0);
        wait_idle();
        chk("R7 timeout", seq_timeout, 1);
        chk("R7 bypass kept", pll_bypass, 1);
        lock_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 timeout sticky", seq_timeout, 1);

        // R10 power-down
        cur_tag = "R10";
        send_pwr(1'b0, 1'b1);
        chk("R10 rst_b", pll_rst_b, 0);
        chk("R10 bypass untouched", pll_bypass, 1);
        chk("R10 done", seq_done, 1);
        chk("R10 timeout cleared", seq_timeout, 0);

        // R12 priority
        cur_tag = "R12";
        send_cfg(10'd200, 6'd3, 3'd0, 16'd0, 1'b1, 1'b1);
        chk("R12 cfg wins", seq_busy, 1);
        wait_idle();
        chk("R12 mdiv", pll_mdiv, 200);
        send_pwr(1'b0, 1'b1);
        send_pwr(1'b1, 1'b1);
        chk("R12 up over down", seq_busy, 1);
        wait_idle();
        chk("R12 rst_b", pll_rst_b, 1);

        repeat (2) @(negedge clk);
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule